// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits over several clocks and returns a signed product of `2*WIDTH` bits. A request is a one-cycle `start` pulse presented while the unit is idle. The operands are captured on that edge. The unit then spends exactly `WIDTH` clocks on the calculation, handling one multiplier bit per clock.

Each clock, the unit looks at two bits: the multiplier bit now at the bottom of the working register, and the bit that was shifted out of that position on the previous clock. That pair decides whether the multiplicand is added to the upper part of the working register, subtracted from it, or left out. The whole register then shifts right arithmetically by one place. The upper part is kept one bit wider than the operands. As a result, the most negative multiplicand is negated without losing its sign.

A caller with narrower operands must sign-extend them to `WIDTH` bits before presenting them.

Top module: `booth_seq_mul`

## Requirements
- R1: During and after synchronous reset, `busy`, `done` and `product` are all 0.
- R2: A `start` seen high at a clock edge while `busy` is low captures both operands and raises `busy` in the next cycle. `done` is high in the cycle that follows the `WIDTH`-th clock edge after the capturing edge.
- R3: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value.
- R5: Operands equal to the most negative value give the correct result. At 8 bits, -128 × -128 = 0x4000 and -128 × 127 = 0xC080.
- R6: A `start` pulse while `busy` is high has no effect. It changes neither the result nor the cycle in which `done` rises.
- R7: After `done`, `product` keeps its value until the next accepted `start`.
- R8: At 8 bits, 2 × -3 (operands 0x02 and 0xFD) gives 0xFFFA.
- R9: A `start` presented in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken only while idle |
| mcand_in | input | WIDTH | Multiplicand, two's complement |
| mplier_in | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held after completion |

## Verification
The hardest case to reach from the ports is a `start` that arrives while an operation is in progress. To check that it is ignored, the bench launches one multiplication and then raises `start` in the middle of it with different operands. It then checks that both the result and the completion cycle still belong to the first request. Operand patterns include alternating bit runs, so that add and subtract steps follow one another on consecutive clocks. They also include the most negative value, which drives the widened upper adder to its limits.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'b00,
        BOOTH_ADD  = 2'b01,
        BOOTH_SUB  = 2'b10
    } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mul_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);

    // Pair (current, previous): 10 begins a run of ones, 01 ends one.
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   op = BOOTH_SUB;
            2'b01:   op = BOOTH_ADD;
            default: op = BOOTH_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH-1:0] mcand,
    input  booth_op_e        op,
    output logic [WIDTH:0]   sum
);

    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] mcand_ext;
    logic [EXT_W-1:0] operand;
    logic             carry_in;

    always_comb begin
        mcand_ext = {mcand[WIDTH-1], mcand};
        carry_in  = 1'b0;
        operand   = '0;
        unique case (op)
            BOOTH_ADD: operand = mcand_ext;
            BOOTH_SUB: begin
                // Subtraction as the inverted operand plus one.
                operand  = ~mcand_ext;
                carry_in = 1'b1;
            end
            default:   operand = '0;
        endcase
        sum = acc + operand + {{(EXT_W-1){1'b0}}, carry_in};
    end

endmodule

// File: rtl/booth_iter_ctr.sv
module booth_iter_ctr #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic last
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = '0;
        else if (step)
            count_d = (count_q == LAST_IDX) ? '0 : count_q + 1'b1;
        last = step && (count_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= LAST_IDX); // R2

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int ACC_W = WIDTH + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] low;
        logic             aux;
        logic [WIDTH-1:0] mcand;
    } mul_state_t;

    mul_state_t state_d, state_q;

    booth_op_e        step_op;
    logic [ACC_W-1:0] step_sum;
    logic             accept;
    logic             last_step;

    assign accept = start && !state_q.busy;

    booth_recoder u_recode (
        .cur_bit  (state_q.low[0]),
        .prev_bit (state_q.aux),
        .op       (step_op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc   (state_q.acc),
        .mcand (state_q.mcand),
        .op    (step_op),
        .sum   (step_sum)
    );

    booth_iter_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (state_q.busy),
        .last (last_step)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (accept) begin
            state_d.busy  = 1'b1;
            state_d.acc   = '0;
            state_d.low   = mplier_in;
            state_d.aux   = 1'b0;
            state_d.mcand = mcand_in;
        end else if (state_q.busy) begin
            // Arithmetic right shift of {sum, low, aux}.
            state_d.acc = {step_sum[ACC_W-1], step_sum[ACC_W-1:1]};
            state_d.low = {step_sum[0], state_q.low[WIDTH-1:1]};
            state_d.aux = state_q.low[0];
            if (last_step) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign busy    = state_q.busy;
    assign done    = state_q.done;
    assign product = {state_q.acc[WIDTH-1:0], state_q.low};

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3
    AST_MCAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(state_q.mcand)); // R6
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(product)); // R7

endmodule

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;

    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    localparam logic [W-1:0] VA [0:NVEC-1] = '{8'h02, 8'h00, 8'h01, 8'hFF, 8'h55,
                                              8'hAA, 8'h7F, 8'h80, 8'h80, 8'h13};
    localparam logic [W-1:0] VB [0:NVEC-1] = '{8'hFD, 8'h5A, 8'h7F, 8'hFF, 8'hAA,
                                              8'h55, 8'h7F, 8'h80, 8'h7F, 8'hE7};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   a = '0, b = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;

    booth_seq_mul #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .mcand_in(a), .mplier_in(b),
        .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 100000) begin
            fails = fails + 1;
            $display("FAIL R2 watchdog expired: got busy=%0b expected completion", busy);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [2*W-1:0] xs, ys;
        xs = $signed({{W{x[W-1]}}, x});
        ys = $signed({{W{y[W-1]}}, y});
        return xs * ys;
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Starts at a negedge; returns at the negedge where done is high.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                          input bit poke, output int cycles);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = ~x; b = ~y;
        cycles = 0;
        while (!done && cycles < 4*W) begin
            if (poke && cycles == 3) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cycles = cycles + 1;
        end
    endtask

    initial begin
        int cyc;
        logic [2*W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset busy", {15'd0, busy}, '0);
        check("R1 reset done", {15'd0, done}, '0);
        check("R1 reset product", product, '0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VA[i], VB[i], 1'b0, cyc);
            check("R2 latency", 16'(cyc), 16'(W));
            check("R4 product", product, ref_mul(VA[i], VB[i]));
            held = product;
            @(negedge clk);
            check("R3 done one cycle", {15'd0, done}, '0);
            repeat (3) @(negedge clk);
            check("R7 product held", product, held);
        end

        // R8 worked example
        run_op(8'h02, 8'hFD, 1'b0, cyc);
        check("R8 2 x -3", product, 16'hFFFA);
        @(negedge clk);

        // R5 most negative operands
        run_op(8'h80, 8'h80, 1'b0, cyc);
        check("R5 -128 x -128", product, 16'h4000);
        @(negedge clk);
        run_op(8'h80, 8'h7F, 1'b0, cyc);
        check("R5 -128 x 127", product, 16'hC080);
        @(negedge clk);

        // R6 start while busy ignored
        run_op(8'h35, 8'hC4, 1'b1, cyc);
        check("R6 timing unchanged", 16'(cyc), 16'(W));
        check("R6 result unchanged", product, ref_mul(8'h35, 8'hC4));
        @(negedge clk);
        check("R6 no extra op busy", {15'd0, busy}, '0);

        // R9 back to back: start in the done cycle
        run_op(8'h11, 8'h22, 1'b0, cyc);
        check("R9 first result", product, ref_mul(8'h11, 8'h22));
        check("R3 busy low with done", {15'd0, busy}, '0);
        run_op(8'hF0, 8'h0F, 1'b0, cyc);
        check("R9 second latency", 16'(cyc), 16'(W));
        check("R9 second result", product, ref_mul(8'hF0, 8'h0F));

        // R1 reset in the middle of an operation
        a = 8'h7F; b = 8'h7F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-op busy", {15'd0, busy}, '0);
        check("R1 reset mid-op product", product, '0);
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule